// File: doc/BRIEF.md
# Boot Source Selector with Low-Window Address Remap

This block picks the memory that a processor boots from and makes it visible at address zero. After reset is released, it waits a fixed number of rising clock edges. It then captures a boot pin and a stored option bit and turns them into one of three boot sources: main flash, system memory or SRAM. A wake-up strobe that marks the end of a low-power standby period restarts the same wait and capture, so the selection can change without a full reset.

The captured source drives an address remapper placed in front of the memory decode. Any bus address inside the 64 KB window at zero is redirected to the same offset inside the selected memory. Every other address goes through unchanged. The translated address is registered, so it appears one clock after the address is presented. Alongside the source code, a valid flag tells downstream logic whether a capture has been taken since the last reset or wake-up.

Top module: `boot_alias_top`

## Requirements
- R1: While reset is high at a clock edge, the registered outputs clear: `sel_valid_o` = 0, `boot_sel_o` = 0 (main flash) and `mapped_addr_o` = 0.
- R2: After reset is released, `sel_valid_o` stays 0 through the first three rising edges. On the fourth rising edge it becomes 1. The boot pin and option bit are captured on that fourth edge, using the values present just before it.
- R3: A captured boot pin of 0 gives `boot_sel_o` = 2'd0 (main flash), whatever the option bit is.
- R4: A captured boot pin of 1 with option bit 1 gives `boot_sel_o` = 2'd1 (system memory).
- R5: A captured boot pin of 1 with option bit 0 gives `boot_sel_o` = 2'd2 (SRAM). The code 2'd3 never appears.
- R6: Once captured, `boot_sel_o` and `sel_valid_o` = 1 hold. Later changes on the boot pin or option bit have no effect until the next reset or wake-up strobe.
- R7: A wake-up strobe seen high at a rising edge clears `sel_valid_o` at that edge and restarts the count, with that edge counted as zero. `boot_sel_o` keeps its old value until a new capture is taken on the fourth rising edge after the strobe edge, which also sets `sel_valid_o` again.
- R8: When `addr_i` is below 0x0001_0000, `mapped_addr_o` is, one clock later, the base of the currently held source plus `addr_i[15:0]`. The bases are main flash 0x0800_0000, system memory 0x1FFF_D800 and SRAM 0x2000_0000.
- R9: When `addr_i` is 0x0001_0000 or above, `mapped_addr_o` is `addr_i` unchanged, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| wake_i | input | 1 | Standby wake-up strobe; restarts the capture count |
| boot_pin_i | input | 1 | External boot select pin |
| boot_opt_i | input | 1 | Stored option bit; chooses system memory (1) or SRAM (0) when the pin is 1 |
| addr_i | input | 32 | Bus address to translate |
| boot_sel_o | output | 2 | Held boot source: 0 flash, 1 system memory, 2 SRAM |
| sel_valid_o | output | 1 | High once a capture has been taken since the last reset or wake-up |
| mapped_addr_o | output | 32 | Translated address, registered |

## Verification
On every cycle, the assertions check four things. The source code is always one of the three legal values. The held source never changes while the valid flag stays high. A wake-up strobe always drops the valid flag. Addresses outside the window come back unchanged one clock later. At the moment the valid flag rises, they also check that the captured source matches the pin and option values of the previous cycle. The bench scenarios are needed for the exact edge count to the capture, the base-plus-offset values for each source, the window boundary at 0xFFFF and 0x10000, and the fact that pin changes after the capture are ignored.

// File: rtl/boot_alias_pkg.sv
package boot_alias_pkg;

  typedef enum logic [1:0] {
    SRC_FLASH  = 2'd0,
    SRC_SYSMEM = 2'd1,
    SRC_SRAM   = 2'd2
  } boot_src_t;

  // Pin low always selects flash; pin high lets the option bit choose.
  function automatic boot_src_t decode_src(input logic pin, input logic opt);
    if (!pin)
      return SRC_FLASH;
    else if (opt)
      return SRC_SYSMEM;
    else
      return SRC_SRAM;
  endfunction

endpackage

// File: rtl/boot_latch_ctl.sv
module boot_latch_ctl
  import boot_alias_pkg::*;
#(
  parameter int LATCH_EDGE = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wake_i,
  input  logic      pin_i,
  input  logic      opt_i,
  output boot_src_t src_o,
  output logic      valid_o
);

  localparam int CNT_W = $clog2(LATCH_EDGE + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LATCH_EDGE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             valid_q;
  boot_src_t        src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      valid_q <= 1'b0;
      src_q   <= SRC_FLASH;
    end else if (wake_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      valid_q <= 1'b0;
    end else if (armed_q) begin
      if (cnt_q == LAST_CNT) begin
        src_q   <= decode_src(pin_i, opt_i);
        valid_q <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign src_o   = src_q;
  assign valid_o = valid_q;

  // R5
  src_legal_chk: assert property (@(posedge clk) disable iff (rst)
    src_q != 2'd3);

  // R6
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q)) |-> $stable(src_q));

  // R7
  wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wake_i |=> !valid_q);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> (src_q == decode_src($past(pin_i), $past(opt_i))));

endmodule

// File: rtl/boot_addr_xlate.sv
module boot_addr_xlate
  import boot_alias_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               WIN_BITS    = 16,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] SYSMEM_BASE = 32'h1FFF_D800,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  boot_src_t         src_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HI_W = ADDR_W - WIN_BITS;

  logic              in_win;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] addr_q;

  assign in_win = (addr_i[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
  assign offset = {{HI_W{1'b0}}, addr_i[WIN_BITS-1:0]};

  always_comb begin
    unique case (src_i)
      SRC_SYSMEM: base = SYSMEM_BASE;
      SRC_SRAM:   base = SRAM_BASE;
      default:    base = FLASH_BASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (in_win)
      addr_q <= base + offset;
    else
      addr_q <= addr_i;
  end

  assign addr_o = addr_q;

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i[ADDR_W-1:WIN_BITS] != {HI_W{1'b0}}) |=> (addr_o == $past(addr_i)));

endmodule

// File: rtl/boot_alias_top.sv
module boot_alias_top
  import boot_alias_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 16,
  parameter int LATCH_EDGE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_i,
  input  logic              boot_pin_i,
  input  logic              boot_opt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        boot_sel_o,
  output logic              sel_valid_o,
  output logic [ADDR_W-1:0] mapped_addr_o
);

  boot_src_t src;

  boot_latch_ctl #(.LATCH_EDGE(LATCH_EDGE)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wake_i  (wake_i),
    .pin_i   (boot_pin_i),
    .opt_i   (boot_opt_i),
    .src_o   (src),
    .valid_o (sel_valid_o)
  );

  boot_addr_xlate #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_xlate (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src),
    .addr_i (addr_i),
    .addr_o (mapped_addr_o)
  );

  assign boot_sel_o = src;

endmodule

// File: tb/boot_alias_top_bench.sv
module boot_alias_top_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        pin;
    logic        opt;
    logic [31:0] addr;
    logic [1:0]  mode;
    logic [31:0] exp_addr;
    logic        in_win;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 32'h0000_1234, 2'd0, 32'h0800_1234, 1'b1},
    '{1'b0, 1'b1, 32'h0000_FFFF, 2'd0, 32'h0800_FFFF, 1'b1},
    '{1'b1, 1'b1, 32'h0000_0004, 2'd1, 32'h1FFF_D804, 1'b1},
    '{1'b1, 1'b0, 32'h0000_0000, 2'd2, 32'h2000_0000, 1'b1},
    '{1'b1, 1'b1, 32'h0800_0010, 2'd1, 32'h0800_0010, 1'b0},
    '{1'b1, 1'b0, 32'h0001_0000, 2'd2, 32'h0001_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wake_i = 1'b0;
  logic        boot_pin_i = 1'b0;
  logic        boot_opt_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  boot_sel_o;
  logic        sel_valid_o;
  logic [31:0] mapped_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_alias_top u_boot_alias_top (
    .clk           (clk),
    .rst           (rst),
    .wake_i        (wake_i),
    .boot_pin_i    (boot_pin_i),
    .boot_opt_i    (boot_opt_i),
    .addr_i        (addr_i),
    .boot_sel_o    (boot_sel_o),
    .sel_valid_o   (sel_valid_o),
    .mapped_addr_o (mapped_addr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reset with given pin/option, check reset state, release; ends at negedge after release.
  task automatic do_reset(input logic pin, input logic opt);
    @(negedge clk);
    rst = 1'b1;
    boot_pin_i = pin;
    boot_opt_i = opt;
    step();
    check("R1 valid in reset", {31'b0, sel_valid_o}, 32'd0);
    check("R1 mode in reset", {30'b0, boot_sel_o}, 32'd0);
    check("R1 addr in reset", mapped_addr_o, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    // Table walk: each vector resets, waits for capture, then translates one address.
    for (int i = 0; i < NVEC; i++) begin
      do_reset(VECS[i].pin, VECS[i].opt);
      repeat (3) step();
      check("R2 valid low after third edge", {31'b0, sel_valid_o}, 32'd0);
      step();
      check("R2 valid high at fourth edge", {31'b0, sel_valid_o}, 32'd1);
      check(VECS[i].mode == 2'd0 ? "R3 flash decode" :
            VECS[i].mode == 2'd1 ? "R4 sysmem decode" : "R5 sram decode",
            {30'b0, boot_sel_o}, {30'b0, VECS[i].mode});
      addr_i = VECS[i].addr;
      step();
      check(VECS[i].in_win ? "R8 window remap" : "R9 pass-through",
            mapped_addr_o, VECS[i].exp_addr);
    end

    // R2: value just before the fourth edge is the one captured
    do_reset(1'b0, 1'b0);
    repeat (3) step();
    boot_pin_i = 1'b1;
    boot_opt_i = 1'b1;
    step();
    check("R2 capture uses fourth-edge value", {30'b0, boot_sel_o}, 32'd1);

    // R6: later pin/option changes are ignored
    boot_pin_i = 1'b0;
    boot_opt_i = 1'b0;
    repeat (5) step();
    check("R6 mode held", {30'b0, boot_sel_o}, 32'd1);
    check("R6 valid held", {31'b0, sel_valid_o}, 32'd1);
    addr_i = 32'h0000_0100;
    step();
    check("R6 remap still uses held source", mapped_addr_o, 32'h1FFF_D900);

    // R7: wake-up strobe restarts count, new capture on fourth edge after strobe edge
    boot_pin_i = 1'b1;
    boot_opt_i = 1'b0;
    wake_i = 1'b1;
    step();
    wake_i = 1'b0;
    check("R7 valid drops on wake", {31'b0, sel_valid_o}, 32'd0);
    check("R7 mode kept until recapture", {30'b0, boot_sel_o}, 32'd1);
    repeat (3) step();
    check("R7 valid low before fourth edge", {31'b0, sel_valid_o}, 32'd0);
    step();
    check("R7 valid back after wake", {31'b0, sel_valid_o}, 32'd1);
    check("R7 new source captured", {30'b0, boot_sel_o}, 32'd2);
    addr_i = 32'h0000_0010;
    step();
    check("R8 remap to sram after wake", mapped_addr_o, 32'h2000_0010);
    addr_i = 32'hFFFF_FFFF;
    step();
    check("R9 top address passes", mapped_addr_o, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule